// File: doc/BRIEF.md
# Interrupt Routing Configuration Register File

This block holds the routing configuration for a bank of interrupt inputs and exposes it through an indirect register pair. A bus master first writes an internal register index into a 32-bit select register, then reads or writes a 32-bit data window. Behind the window sit a 4-bit identifier, a constant version word, an arbitration word that mirrors the identifier, and one 64-bit routing entry per interrupt input. Each entry is split into a low and a high 32-bit half.

Two status bits in each entry's low half belong to delivery hardware elsewhere. Window writes can never alter them. Every entry comes out of reset masked. Each accepted write to an entry half raises a one-cycle update strobe that carries the entry number, and it sets a sticky per-entry in-use flag, so downstream logic knows which routes to reload. The block only stores configuration and returns it. It does not deliver interrupts.

Top module: `irq_route_regfile`

## Requirements
- R1: Byte offset 0x00 of `req_addr_i` is the select register and 0x10 is the data window. A write to any other offset changes nothing. A read of any other offset returns 0.
- R2: Only accesses with `req_size_i` equal to 4 (bytes) are accepted. Any other size gives no response and changes no state.
- R3: The select register stores and returns all 32 written bits. Only its low 8 bits form the internal index.
- R4: A write to index 0x00 stores data bits 27:24 as the identifier. A read of index 0x00 or index 0x02 returns the identifier in bits 27:24, with every other bit 0. Writes to index 0x02 are ignored.
- R5: Index 0x01 always reads 0x0017_0011, where bits 23:16 hold the entry count minus one. A zero write to it is accepted silently. A nonzero write changes nothing and pulses `wr_err_o` in the cycle after the write.
- R6: Entry n (0..23) has its low half at index 0x10+2n and its high half at index 0x11+2n. Index bit 0 selects the half.
- R7: A write to an entry's low half leaves bit 12 and bit 14 at their stored values, which are 0 after reset. All other low bits take the written data.
- R8: After reset every entry reads 0x0000_0000_0001_0000, with mask bit 16 set. The identifier and the select register are 0, and `in_use_o` is 0.
- R9: In the cycle after an accepted window write to either half of entry n, `upd_valid_o` is high for one cycle with `upd_idx_o` = n, and `in_use_o[n]` becomes 1 and stays 1 until reset.
- R10: Indices 0x03 to 0x0F and indices above 0x3F read as 0. Writes to them are ignored and raise no update strobe.
- R11: An accepted read gives `rsp_valid_o` high with `rsp_rdata_o` in the following cycle. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the access |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| wr_err_o | output | 1 | Rejected nonzero write to the version word |
| upd_valid_o | output | 1 | Entry update strobe |
| upd_idx_o | output | 5 | Updated entry number |
| in_use_o | output | 24 | Sticky per-entry written flags |

## Verification
The assertions check several things on every cycle: that a low-half write keeps both status bits, that the update strobe names a valid entry already flagged in use, that in-use flags never clear, that wrong-size accesses and writes produce no response, and that a nonzero version write is reported. Only the bench scenarios can show the values that come back through the window: the index-to-entry mapping, the identifier placement, the constant version word, the reset contents, and the zero reads of unmapped offsets and indices.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;
  localparam logic [7:0]  SEL_OFF   = 8'h00;
  localparam logic [7:0]  WIN_OFF   = 8'h10;
  localparam logic [7:0]  IX_ID     = 8'h00;
  localparam logic [7:0]  IX_VER    = 8'h01;
  localparam logic [7:0]  IX_ARB    = 8'h02;
  localparam logic [7:0]  IX_ENT0   = 8'h10;
  localparam logic [31:0] LO_RO_MSK = 32'h0000_5000; // status bits 14 and 12
  localparam logic [63:0] ENT_RST   = 64'h0000_0000_0001_0000;
  localparam logic [2:0]  ACC_BYTES = 3'd4;
endpackage

// File: rtl/irq_rf_decode.sv
module irq_rf_decode #(
  parameter int NUM_ENT = 24,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic [7:0]       ix_i,
  output logic             hit_id_o,
  output logic             hit_ver_o,
  output logic             hit_arb_o,
  output logic             hit_ent_o,
  output logic [IDX_W-1:0] ent_idx_o,
  output logic             ent_hi_o
);
  import irq_rf_pkg::*;
  localparam int ENT_LAST = int'(IX_ENT0) + 2*NUM_ENT - 1;

  logic [7:0] rel;

  always_comb begin
    rel       = ix_i - IX_ENT0;
    hit_id_o  = (ix_i == IX_ID);
    hit_ver_o = (ix_i == IX_VER);
    hit_arb_o = (ix_i == IX_ARB);
    hit_ent_o = (ix_i >= IX_ENT0) && (int'(ix_i) <= ENT_LAST);
    ent_idx_o = rel[IDX_W:1];
    ent_hi_o  = ix_i[0];
  end
endmodule

// File: rtl/irq_rf_entry_bank.sv
module irq_rf_entry_bank #(
  parameter int NUM_ENT = 24,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_hi_i,
  input  logic [31:0]        wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  input  logic               rd_hi_i,
  output logic [31:0]        rd_data_o,
  output logic [NUM_ENT-1:0] in_use_o
);
  import irq_rf_pkg::*;

  logic [63:0] ent_q [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic sel_w;
    assign sel_w = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[i]    <= ENT_RST;
        in_use_o[i] <= 1'b0;
      end else if (sel_w) begin
        in_use_o[i] <= 1'b1;
        if (wr_hi_i) ent_q[i][63:32] <= wr_data_i;
        else         ent_q[i][31:0]  <= (wr_data_i & ~LO_RO_MSK) | (ent_q[i][31:0] & LO_RO_MSK);
      end
    end

    assert_ro_bits_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_w && !wr_hi_i) |=> ($stable(ent_q[i][12]) && $stable(ent_q[i][14])));
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_ENT; i++)
      if (rd_idx_i == IDX_W'(i))
        rd_data_o = rd_hi_i ? ent_q[i][63:32] : ent_q[i][31:0];
  end

  assert_in_use_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(in_use_o) & ~in_use_o) == '0);
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile #(
  parameter int          NUM_ENT = 24,
  parameter logic [7:0]  VER_ID  = 8'h11,
  localparam int         IDX_W   = $clog2(NUM_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [7:0]         req_addr_i,
  input  logic [2:0]         req_size_i,
  input  logic [31:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [31:0]        rsp_rdata_o,
  output logic               wr_err_o,
  output logic               upd_valid_o,
  output logic [IDX_W-1:0]   upd_idx_o,
  output logic [NUM_ENT-1:0] in_use_o
);
  import irq_rf_pkg::*;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENT-1), 8'h00, VER_ID};

  logic [31:0]      sel_q;
  logic [3:0]       id_q;
  logic             acc_ok, at_sel, at_win, wr_sel, wr_win, rd_go;
  logic             hit_id, hit_ver, hit_arb, hit_ent, ent_hi;
  logic [IDX_W-1:0] ent_idx;
  logic [31:0]      ent_rd, win_val, rd_next;

  assign acc_ok = req_valid_i && (req_size_i == ACC_BYTES);
  assign at_sel = (req_addr_i == SEL_OFF);
  assign at_win = (req_addr_i == WIN_OFF);
  assign wr_sel = acc_ok && req_write_i && at_sel;
  assign wr_win = acc_ok && req_write_i && at_win;
  assign rd_go  = acc_ok && !req_write_i;

  irq_rf_decode #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_dec (
    .ix_i     (sel_q[7:0]),
    .hit_id_o (hit_id),
    .hit_ver_o(hit_ver),
    .hit_arb_o(hit_arb),
    .hit_ent_o(hit_ent),
    .ent_idx_o(ent_idx),
    .ent_hi_o (ent_hi)
  );

  irq_rf_entry_bank #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_win && hit_ent),
    .wr_idx_i (ent_idx),
    .wr_hi_i  (ent_hi),
    .wr_data_i(req_wdata_i),
    .rd_idx_i (ent_idx),
    .rd_hi_i  (ent_hi),
    .rd_data_o(ent_rd),
    .in_use_o (in_use_o)
  );

  always_comb begin
    win_val = '0;
    if (hit_id || hit_arb) win_val = {4'h0, id_q, 24'h0};
    else if (hit_ver)      win_val = VER_WORD;
    else if (hit_ent)      win_val = ent_rd;
    rd_next = at_sel ? sel_q : (at_win ? win_val : 32'h0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= '0;
      id_q        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      wr_err_o    <= 1'b0;
      upd_valid_o <= 1'b0;
      upd_idx_o   <= '0;
    end else begin
      rsp_valid_o <= rd_go;
      if (rd_go) rsp_rdata_o <= rd_next;
      if (wr_sel) sel_q <= req_wdata_i;
      if (wr_win && hit_id) id_q <= req_wdata_i[27:24];
      wr_err_o    <= wr_win && hit_ver && (req_wdata_i != '0);
      upd_valid_o <= wr_win && hit_ent;
      if (wr_win && hit_ent) upd_idx_o <= ent_idx;
    end
  end

  assert_bad_size_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i != ACC_BYTES) |=> (!rsp_valid_o && !upd_valid_o && !wr_err_o));

  assert_no_rsp_on_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> !rsp_valid_o);

  assert_ver_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && req_write_i && at_win && sel_q[7:0] == IX_VER && req_wdata_i != '0) |=> wr_err_o);

  assert_upd_marks_use_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (int'(upd_idx_o) < NUM_ENT && in_use_o[upd_idx_o]));

  assert_id_field_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go && at_win && (sel_q[7:0] == IX_ID || sel_q[7:0] == IX_ARB))
      |=> (rsp_rdata_o[31:28] == 4'h0 && rsp_rdata_o[23:0] == 24'h0));
endmodule

// File: tb/irq_route_regfile_tb.sv
module irq_route_regfile_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [2:0]  req_size_i = 3'd4;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o, wr_err_o, upd_valid_o;
  logic [31:0] rsp_rdata_o;
  logic [4:0]  upd_idx_o;
  logic [23:0] in_use_o;

  int checks = 0;
  int errors = 0;
  logic        s_rv, s_err, s_uv;
  logic [31:0] s_rd;
  logic [4:0]  s_ui;

  always #10 clk_i = ~clk_i;

  irq_route_regfile u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [2:0] sz);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = w; req_addr_i = a; req_wdata_i = d; req_size_i = sz;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    s_rv = rsp_valid_o; s_rd = rsp_rdata_o; s_err = wr_err_o; s_uv = upd_valid_o; s_ui = upd_idx_o;
  endtask

  task automatic sel(input logic [31:0] ix);
    access(1'b1, 8'h00, ix, 3'd4);
  endtask

  task automatic win_rd(input logic [31:0] ix, output logic [31:0] v);
    sel(ix);
    access(1'b0, 8'h10, 32'h0, 3'd4);
    v = s_rd;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R8 in_use", 32'(in_use_o), 32'h0);
    access(1'b0, 8'h00, 32'h0, 3'd4);
    chk("R8 select", s_rd, 32'h0);
    chk("R11 rsp_valid", 32'(s_rv), 32'h1);
    win_rd(32'h10, v); chk("R8 entry0 lo", v, 32'h0001_0000);
    win_rd(32'h3E, v); chk("R8 entry23 lo", v, 32'h0001_0000);
    win_rd(32'h3F, v); chk("R8 entry23 hi", v, 32'h0);
    win_rd(32'h00, v); chk("R8 id", v, 32'h0);
  endtask

  task automatic t_select;
    sel(32'hABCD_1234);
    chk("R11 no rsp on write", 32'(s_rv), 32'h0);
    access(1'b0, 8'h00, 32'h0, 3'd4);
    chk("R3 select readback", s_rd, 32'hABCD_1234);
  endtask

  task automatic t_version;
    logic [31:0] v;
    win_rd(32'h01, v); chk("R5 version", v, 32'h0017_0011);
    access(1'b1, 8'h10, 32'h0, 3'd4);
    chk("R5 zero write no err", 32'(s_err), 32'h0);
    access(1'b1, 8'h10, 32'h5, 3'd4);
    chk("R5 nonzero write err", 32'(s_err), 32'h1);
    access(1'b0, 8'h10, 32'h0, 3'd4);
    chk("R5 version kept", s_rd, 32'h0017_0011);
  endtask

  task automatic t_id;
    logic [31:0] v;
    sel(32'h00);
    access(1'b1, 8'h10, 32'hFFFF_FFFF, 3'd4);
    chk("R10 id write no upd", 32'(s_uv), 32'h0);
    win_rd(32'h00, v); chk("R4 id read", v, 32'h0F00_0000);
    win_rd(32'h02, v); chk("R4 arb read", v, 32'h0F00_0000);
    access(1'b1, 8'h10, 32'h0, 3'd4);
    win_rd(32'h00, v); chk("R4 arb write ignored", v, 32'h0F00_0000);
    sel(32'h00); access(1'b1, 8'h10, 32'h0500_0000, 3'd4);
    win_rd(32'h02, v); chk("R4 id update", v, 32'h0500_0000);
  endtask

  task automatic t_entries;
    logic [31:0] v;
    sel(32'h1A);
    access(1'b1, 8'h10, 32'hFFFF_FFFF, 3'd4);
    chk("R9 upd valid", 32'(s_uv), 32'h1);
    chk("R9 upd idx lo", 32'(s_ui), 32'd5);
    chk("R9 in_use 5", 32'(in_use_o), 32'h20);
    access(1'b0, 8'h10, 32'h0, 3'd4);
    chk("R7 ro bits kept", s_rd, 32'hFFFF_AFFF);
    sel(32'h1B);
    access(1'b1, 8'h10, 32'hAB00_0000, 3'd4);
    chk("R9 upd idx hi", 32'(s_ui), 32'd5);
    access(1'b0, 8'h10, 32'h0, 3'd4);
    chk("R6 entry5 hi", s_rd, 32'hAB00_0000);
    win_rd(32'h1A, v); chk("R6 entry5 lo unchanged", v, 32'hFFFF_AFFF);
    sel(32'h3F); access(1'b1, 8'h10, 32'h1200_0000, 3'd4);
    chk("R9 upd idx 23", 32'(s_ui), 32'd23);
    sel(32'h10); access(1'b1, 8'h10, 32'h0000_0031, 3'd4);
    chk("R9 upd idx 0", 32'(s_ui), 32'd0);
    win_rd(32'h10, v); chk("R6 entry0 lo", v, 32'h0000_0031);
    win_rd(32'h3F, v); chk("R6 entry23 hi", v, 32'h1200_0000);
    win_rd(32'h3E, v); chk("R6 entry23 lo", v, 32'h0001_0000);
    chk("R9 sticky in_use", 32'(in_use_o), 32'h0080_0021);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    sel(32'h40); access(1'b1, 8'h10, 32'h1234_5678, 3'd4);
    chk("R10 idx 0x40 no upd", 32'(s_uv), 32'h0);
    access(1'b0, 8'h10, 32'h0, 3'd4);
    chk("R10 idx 0x40 reads 0", s_rd, 32'h0);
    win_rd(32'h05, v); chk("R10 idx 0x05 reads 0", v, 32'h0);
    win_rd(32'h3E, v); chk("R10 entry23 lo intact", v, 32'h0001_0000);
    sel(32'h22);
    access(1'b1, 8'h04, 32'h0000_0010, 3'd4);
    chk("R1 bad offset write no upd", 32'(s_uv), 32'h0);
    access(1'b0, 8'h00, 32'h0, 3'd4);
    chk("R1 select unchanged", s_rd, 32'h22);
    access(1'b0, 8'h04, 32'h0, 3'd4);
    chk("R1 bad offset read 0", s_rd, 32'h0);
    chk("R1 bad offset read valid", 32'(s_rv), 32'h1);
  endtask

  task automatic t_size;
    access(1'b1, 8'h00, 32'h10, 3'd2);
    access(1'b0, 8'h00, 32'h0, 3'd4);
    chk("R2 select kept", s_rd, 32'h22);
    access(1'b0, 8'h00, 32'h0, 3'd1);
    chk("R2 no rsp", 32'(s_rv), 32'h0);
    sel(32'h12);
    access(1'b1, 8'h10, 32'h0, 3'd2);
    chk("R2 no upd", 32'(s_uv), 32'h0);
    access(1'b0, 8'h10, 32'h0, 3'd4);
    chk("R2 entry1 kept", s_rd, 32'h0001_0000);
    chk("R2 in_use kept", 32'(in_use_o), 32'h0080_0021);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_select;
    t_version;
    t_id;
    t_entries;
    t_unmapped;
    t_size;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule